// File: doc/BRIEF.md
# Port Edge Interrupt Detector

The block watches eight general-purpose port pins, split into two groups of four, and raises a single shared interrupt request when a selected edge appears on any pin that is configured as an input. A per-pin direction mask removes pins that are driving as outputs. A polarity bit chooses falling or rising edges.

After one edge has set the request, the detector stays disarmed. It ignores further edges of the selected kind until every participating input pin is back at its idle level. The idle level is high in falling mode and low in rising mode. Software sees a sticky request flag. It clears that flag with a strobe, and it holds an enable flag through write strobes. The interrupt output is the request gated by the enable. When the interrupt is accepted, the enable is dropped by hardware.

The pin levels arrive already synchronized to the clock. The detector keeps its own registered copy of the previous levels for edge detection.

Top module: `port_edge_irq`

## Requirements
- R1: The eight pins form two groups of four (bits 3:0 and bits 7:4 of `pins_i`). An edge on a pin in either group sets the same request flag `req_o`.
- R2: A pin whose `dir_out_i` bit is 1 is an output. It never sets the request, and its level does not stop the detector from re-arming.
- R3: With the polarity at 0 (falling), an input pin that is high at one clock edge and low at the next sets `req_o`, visible right after that second clock edge.
- R4: In falling mode, once an edge has set the request, no further falling edge sets it. This holds until all input pins have been sampled high together. The next falling edge after that sets it again.
- R5: With the polarity at 1 (rising), a low-to-high transition on an input pin sets `req_o`. Further rising edges are ignored until all input pins have been sampled low together.
- R6: `irq_o` is 1 exactly when `req_o` and `en_o` are both 1.
- R7: A pulse on `ack_i` clears `en_o` on the next clock edge and leaves `req_o` unchanged. If `ack_i` and `en_we_i` are both high in the same cycle, `ack_i` wins.
- R8: A pulse on `req_clr_i` clears `req_o` on the next clock edge. If an edge is detected in the same cycle, the request stays set.
- R9: After reset, `req_o`, `en_o`, `edge_o` and `irq_o` are 0 and the detector is armed. No edge is detected in the first cycle after reset.
- R10: A write that changes the polarity disarms the detector. It re-arms only once all input pins sit at the new idle level.
- R11: `en_we_i` loads `en_d_i` into the enable, and `edge_we_i` loads `edge_d_i` into the polarity. Each new value shows on `en_o` or `edge_o` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 8 | Synchronized pin levels, group 0 in bits 3:0, group 1 in bits 7:4 |
| dir_out_i | input | 8 | Per-pin direction, 1 = output (ignored), 0 = input |
| edge_we_i | input | 1 | Polarity write strobe |
| edge_d_i | input | 1 | Polarity write data, 0 = falling, 1 = rising |
| en_we_i | input | 1 | Enable write strobe |
| en_d_i | input | 1 | Enable write data |
| ack_i | input | 1 | Interrupt accepted, clears the enable |
| req_clr_i | input | 1 | Request clear strobe |
| req_o | output | 1 | Sticky request flag |
| irq_o | output | 1 | Interrupt, request gated by enable |
| en_o | output | 1 | Current enable flag |
| edge_o | output | 1 | Current polarity |

## Verification
The assertions take for granted that the pin levels are already synchronous to the clock. They also assume that the strobes are single-cycle pulses sampled only at rising clock edges. The stimulus therefore changes pins, direction bits and strobes only on the falling clock edge. It drops each strobe after exactly one cycle. In the random phase it drives all pins to a common level from time to time, so the re-arm path is reached as often as the edge path.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/port_irq_edge_det.sv
module port_irq_edge_det
  import port_irq_pkg::*;
#(
  parameter int PIN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIN_W-1:0] pins_i,
  input  logic [PIN_W-1:0] dir_out_i,
  input  edge_pol_e        pol_i,
  output logic             hit_o,
  output logic             all_idle_o
);
  logic [PIN_W-1:0] prev_q;
  logic             vld_q;
  logic [PIN_W-1:0] edge_vec;
  logic [PIN_W-1:0] idle_vec;
  logic             idle_lvl;

  assign idle_lvl = (pol_i == EDGE_RISE) ? 1'b0 : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= pins_i;
      vld_q  <= 1'b1;
    end
  end

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    assign edge_vec[i] = vld_q & ~dir_out_i[i] & (prev_q[i] == idle_lvl) & (pins_i[i] != idle_lvl);
    assign idle_vec[i] = dir_out_i[i] | (pins_i[i] == idle_lvl);
  end

  assign hit_o      = |edge_vec;
  assign all_idle_o = &idle_vec;

  // R2
  out_pin_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&dir_out_i) |-> !hit_o && all_idle_o);
endmodule

// File: rtl/port_irq_arm.sv
module port_irq_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic all_idle_i,
  input  logic pol_chg_i,
  input  logic req_clr_i,
  output logic req_o
);
  logic armed_q;
  logic req_q;
  logic fire;

  assign fire  = armed_q & hit_i;
  assign req_o = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
    end else if (pol_chg_i || fire) begin
      armed_q <= 1'b0;
    end else if (!armed_q && all_idle_i) begin
      armed_q <= 1'b1;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
    end else if (fire) begin
      req_q <= 1'b1;
    end else if (req_clr_i) begin
      req_q <= 1'b0;
    end
  end

  // R3
  req_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(armed_q));
  // R4
  rearm_on_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(all_idle_i));
  // R10
  disarm_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(armed_q) |-> (req_q || $past(pol_chg_i)));
  // R8
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_clr_i && !hit_i) |=> !req_q);
endmodule

// File: rtl/port_edge_irq.sv
module port_edge_irq
  import port_irq_pkg::*;
#(
  parameter int GROUP_W    = 4,
  parameter int NUM_GROUPS = 2,
  localparam int NUM_PINS  = GROUP_W * NUM_GROUPS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] dir_out_i,
  input  logic                edge_we_i,
  input  logic                edge_d_i,
  input  logic                en_we_i,
  input  logic                en_d_i,
  input  logic                ack_i,
  input  logic                req_clr_i,
  output logic                req_o,
  output logic                irq_o,
  output logic                en_o,
  output logic                edge_o
);
  edge_pol_e             pol_q;
  logic                  en_q;
  logic [NUM_GROUPS-1:0] grp_hit;
  logic [NUM_GROUPS-1:0] grp_idle;
  logic                  pol_chg;
  logic                  req;

  assign pol_chg = edge_we_i & (edge_d_i != pol_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= EDGE_FALL;
    end else if (edge_we_i) begin
      pol_q <= edge_pol_e'(edge_d_i);
    end
  end

  // acceptance beats a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else if (ack_i) begin
      en_q <= 1'b0;
    end else if (en_we_i) begin
      en_q <= en_d_i;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    port_irq_edge_det #(.PIN_W(GROUP_W)) u_det (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pins_i     (pins_i[g*GROUP_W +: GROUP_W]),
      .dir_out_i  (dir_out_i[g*GROUP_W +: GROUP_W]),
      .pol_i      (pol_q),
      .hit_o      (grp_hit[g]),
      .all_idle_o (grp_idle[g])
    );
  end

  port_irq_arm u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (|grp_hit),
    .all_idle_i (&grp_idle),
    .pol_chg_i  (pol_chg),
    .req_clr_i  (req_clr_i),
    .req_o      (req)
  );

  assign req_o  = req;
  assign irq_o  = req & en_q;
  assign en_o   = en_q;
  assign edge_o = pol_q;

  // R7
  ack_drops_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !en_o);
  // R11
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_we_i && !ack_i) |=> $stable(en_o));
  // R11
  pol_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_we_i |=> $stable(edge_o));
endmodule

// File: tb/port_edge_irq_tb_top.sv
`timescale 1ns/1ps
module port_edge_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'hFF;
  logic [7:0] dir = 8'h00;
  logic edge_we = 0, edge_d = 0, en_we = 0, en_d = 0, ack = 0, clr = 0;
  logic req_o, irq_o, en_o, edge_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  port_edge_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .dir_out_i(dir),
    .edge_we_i(edge_we), .edge_d_i(edge_d), .en_we_i(en_we), .en_d_i(en_d),
    .ack_i(ack), .req_clr_i(clr),
    .req_o(req_o), .irq_o(irq_o), .en_o(en_o), .edge_o(edge_o)
  );

  // behavioural reference
  bit m_req, m_en, m_rise, m_armed, m_vld;
  bit [7:0] m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_en = 0; m_rise = 0; m_armed = 1; m_vld = 0; m_prev = 0;
    end else begin
      bit idle, fire, quiet, chg;
      idle  = !m_rise;
      fire  = 0;
      quiet = 1;
      for (int i = 0; i < 8; i++) begin
        if (!dir[i]) begin
          if (m_vld && m_prev[i] == idle && pins[i] != idle) fire = 1;
          if (pins[i] != idle) quiet = 0;
        end
      end
      fire = fire && m_armed;
      chg  = edge_we && (edge_d != m_rise);
      if (fire) m_req = 1;
      else if (clr) m_req = 0;
      if (chg || fire) m_armed = 0;
      else if (!m_armed && quiet) m_armed = 1;
      if (ack) m_en = 0;
      else if (en_we) m_en = en_d;
      if (edge_we) m_rise = edge_d;
      m_prev = pins;
      m_vld  = 1;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 model req", req_o, m_req);
      chk("R6 model irq", irq_o, m_req && m_en);
      chk("R7 model en", en_o, m_en);
      chk("R11 model edge", edge_o, m_rise);
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive a one-cycle strobe set, then release
  task automatic pulse_clr();
    clr = 1; tick(1); clr = 0;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R9 req", req_o, 0); chk("R9 en", en_o, 0);
    chk("R9 edge", edge_o, 0); chk("R9 irq", irq_o, 0);
    tick(1);
    en_we = 1; en_d = 1; tick(1); en_we = 0;
    chk("R11 en write", en_o, 1);
    pins = 8'hDF; tick(1);
    chk("R1 group1 pin", req_o, 1); chk("R3 falling", req_o, 1);
    chk("R6 irq", irq_o, 1);
    pulse_clr();
    chk("R8 clear", req_o, 0);
    pins = 8'hDE; tick(1);
    chk("R4 disarmed", req_o, 0);
    pins = 8'hFF; tick(2);
    pins = 8'hFB; tick(1);
    chk("R4 rearmed", req_o, 1);
    ack = 1; en_we = 1; en_d = 1; tick(1); ack = 0; en_we = 0;
    chk("R7 en cleared", en_o, 0); chk("R7 irq low", irq_o, 0);
    chk("R7 req kept", req_o, 1);
    pulse_clr();
    pins = 8'hFF; tick(2);
    clr = 1; pins = 8'hF7; tick(1); clr = 0;
    chk("R8 set wins", req_o, 1);
    pulse_clr();
    pins = 8'hFF; tick(2);
    dir = 8'h40; tick(1);
    pins = 8'hBF; tick(1);
    chk("R2 output ignored", req_o, 0);
    tick(1);
    pins = 8'hBD; tick(1);
    chk("R2 input still fires", req_o, 1);
    pulse_clr();
    pins = 8'hBF; tick(2);
    pins = 8'hBD; tick(1);
    chk("R2 rearm past output", req_o, 1);
    pulse_clr();
    dir = 8'h00; pins = 8'hFF; tick(2);
    edge_we = 1; edge_d = 1; tick(1); edge_we = 0;
    chk("R11 edge write", edge_o, 1);
    pins = 8'hEF; tick(1);
    pins = 8'hFF; tick(1);
    chk("R10 disarm on change", req_o, 0);
    pins = 8'h00; tick(2);
    pins = 8'h02; tick(1);
    chk("R5 rising", req_o, 1);
    pulse_clr();
    pins = 8'h82; tick(1);
    chk("R5 rising ignored", req_o, 0);
    pins = 8'h00; tick(2);
    pins = 8'h80; tick(1);
    chk("R5 rearm rising", req_o, 1);
    pulse_clr();

    for (int c = 0; c < 600; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 25) pins[$urandom_range(0, 7)] ^= 1'b1;
      else if (r < 37) pins = $urandom_range(0, 1) ? 8'hFF : 8'h00;
      if ($urandom_range(0, 15) == 0) dir = 8'($urandom_range(0, 255));
      edge_we = ($urandom_range(0, 19) == 0); edge_d = 1'($urandom_range(0, 1));
      en_we   = ($urandom_range(0, 9) == 0);  en_d   = 1'($urandom_range(0, 1));
      ack     = ($urandom_range(0, 11) == 0);
      clr     = ($urandom_range(0, 5) == 0);
      tick(1);
    end
    edge_we = 0; en_we = 0; ack = 0; clr = 0;
    tick(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule